// File: doc/BRIEF.md
# DS3 Alarm/Control Code Transmitter

This block sends a six-bit far-end alarm and control code over the C-bit overhead channel of a DS3 line. Software loads the code into a code register and sets the enable and go bits in a control/status register. The block then frames the code into a sixteen-bit message and shifts it out one bit each time the framer raises a one-cycle bit-request strobe. Where each strobe falls in the DS3 frame is decided outside the block.

The message goes out ten times back to back. The busy flag falls on the strobe that carries the last bit, and a completion status bit is set at the same moment. Reading the control/status register clears that status bit. A separate enable bit routes the status bit to the interrupt output. While the processor enable bit is low, the block holds the line at one and accepts no go command.

Top module: `feac_tx`

## Requirements
- R1: After reset, the control/status register (offset 0x31) and the code register (offset 0x32) both read 0x00, `tx_bit` is 1 and `irq` is 0.
- R2: The code register holds six bits in bits 5..0 and reads 0 in bits 7..6. In the control/status register, bit 4 is the interrupt enable and bit 2 is the processor enable; both are read/write. Bits 7..5 always read 0. Bit 3 is the completion status and bit 0 is busy; both are read-only.
- R3: Each message is sent in this order: a 0, then code bits d5 down to d0, then a 0, then eight 1s. `tx_bit` takes a new value only in the cycle after a `bit_req` strobe, with one message bit per strobe.
- R4: After a go command, the message is sent ten times in a row (160 strobes). After that, and on every strobe while idle, `tx_bit` is 1.
- R5: Busy (bit 0) reads 1 from the second cycle after an accepted go write until the strobe that carries the 160th bit, and reads 0 from then on.
- R6: Writing a value with bit 1 set to offset 0x31 starts a transmission only when bit 2 of the same write is 1 and the block is not busy. Go (bit 1) clears itself once the transmission has started.
- R7: A go write made while busy is ignored. The running transmission keeps its count, and no second run follows it.
- R8: The completion status (bit 3) sets on the strobe that finishes the tenth message. A read of offset 0x31 returns the current value and then clears the bit. If that read falls in the same cycle as the completion, the bit still sets.
- R9: `irq` is high exactly while the completion status is 1 and the interrupt enable (bit 4) is 1.
- R10: Clearing the processor enable while busy aborts the transmission. Busy falls, later strobes send 1s, and the completion status does not set.
- R11: The code is captured when a transmission starts. Writes to the code register while busy do not change the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears completion status on 0x31) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| bit_req | input | 1 | One-cycle request from the framer for the next line bit |
| tx_bit | output | 1 | Serial alarm/control channel bit |
| irq | output | 1 | Completion interrupt, active high |

## Verification
The code is checked at both extremes: all zeros, where only the fixed trailing 1s are high, and all ones, where only the two framing zeros are low. Two alternating patterns catch a reversed or shifted code field, and random codes fill in the rest. Strobes come with random idle gaps, which separates a line output that advances on each strobe from one that advances on the clock. Directed runs cover four more cases:
- a go command and a code change made mid-run, to tell a latched code and a guarded go from a live one;
- a status read in the completion cycle;
- a run with the interrupt masked;
- an abort by disabling the block.

// File: rtl/feac_pkg.sv
// Package: shared sizes, register offsets and bit positions for the
// alarm/control code transmitter. Assumes a byte-wide register port.
package feac_pkg;
    parameter int CODE_W   = 6;
    parameter int MSG_LEN  = 16;
    parameter int REPEATS  = 10;
    parameter int ADDR_W   = 8;
    parameter int DATA_W   = 8;

    localparam int FILL_W  = MSG_LEN - CODE_W - 2;
    localparam int BIT_W   = $clog2(MSG_LEN);
    localparam int REP_W   = $clog2(REPEATS);

    localparam logic [ADDR_W-1:0] CSR_OFS  = 8'h31;
    localparam logic [ADDR_W-1:0] CODE_OFS = 8'h32;

    localparam int B_BUSY = 0;
    localparam int B_GO   = 1;
    localparam int B_EN   = 2;
    localparam int B_STAT = 3;
    localparam int B_IEN  = 4;
endpackage

// File: rtl/feac_regs.sv
// Module: register file. Holds the code word, enables, the go request and
// the completion status. Assumes reads are combinational and the read
// strobe lasts one cycle per access.
module feac_regs
    import feac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [CODE_W-1:0] code,
    output logic              en,
    output logic              ien,
    output logic              go,
    output logic              stat
);
    logic csr_wr;
    logic csr_rd;
    logic code_wr;
    logic go_ok;
    logic unused_wbits;

    assign csr_wr  = wr && (addr == CSR_OFS);
    assign code_wr = wr && (addr == CODE_OFS);
    assign csr_rd  = rd && (addr == CSR_OFS);
    assign go_ok   = csr_wr && wdata[B_GO] && wdata[B_EN] && !busy && !go;
    assign unused_wbits = ^wdata[DATA_W-1:CODE_W];

    // Code word register.
    always_ff @(posedge clk) begin
        if (!rst_n)       code <= '0;
        else if (code_wr) code <= wdata[CODE_W-1:0];
    end

    // Enable bits, written as a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            ien <= 1'b0;
        end else if (csr_wr) begin
            en  <= wdata[B_EN];
            ien <= wdata[B_IEN];
        end
    end

    // Go request: lives one cycle, consumed by the serializer as a start.
    always_ff @(posedge clk) begin
        if (!rst_n)     go <= 1'b0;
        else if (go)    go <= 1'b0;
        else if (go_ok) go <= 1'b1;
    end

    // Completion status: set has priority over read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat <= 1'b0;
        else if (done)   stat <= 1'b1;
        else if (csr_rd) stat <= 1'b0;
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        if (addr == CSR_OFS) begin
            rdata[B_BUSY] = busy;
            rdata[B_GO]   = go;
            rdata[B_EN]   = en;
            rdata[B_STAT] = stat;
            rdata[B_IEN]  = ien;
        end else if (addr == CODE_OFS) begin
            rdata[CODE_W-1:0] = code;
        end
    end
endmodule

// File: rtl/feac_msg_build.sv
// Module: frames a code word into the line message, first bit in the MSB.
// Assumes the fixed framing of a leading 0, the code d5..d0, a 0 and 1s.
module feac_msg_build
    import feac_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    output logic [MSG_LEN-1:0] msg
);
    // Concatenate framing around the code.
    always_comb begin
        msg = {1'b0, code, 1'b0, {FILL_W{1'b1}}};
    end
endmodule

// File: rtl/feac_serializer.sv
// Module: shifts the captured message out one bit per strobe and repeats
// it REPEATS times. Assumes start is a single-cycle pulse and bit_req is
// at most one cycle wide per requested bit.
module feac_serializer
    import feac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               start,
    input  logic [MSG_LEN-1:0] msg,
    input  logic               bit_req,
    output logic               tx_bit,
    output logic               busy,
    output logic               done
);
    logic [MSG_LEN-1:0] msg_q;
    logic [MSG_LEN-1:0] shreg;
    logic [BIT_W-1:0]   bit_cnt;
    logic [REP_W-1:0]   rep_cnt;
    logic               last_bit;
    logic               last_rep;

    assign last_bit = (bit_cnt == BIT_W'(MSG_LEN - 1));
    assign last_rep = (rep_cnt == REP_W'(REPEATS - 1));
    assign done     = busy && en && bit_req && last_bit && last_rep;

    // Sequencer: capture, shift, count bits and repeats, drive the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q   <= '1;
            shreg   <= '1;
            bit_cnt <= '0;
            rep_cnt <= '0;
            busy    <= 1'b0;
            tx_bit  <= 1'b1;
        end else if (!en) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
            rep_cnt <= '0;
            if (bit_req) tx_bit <= 1'b1;
        end else if (start && !busy) begin
            msg_q   <= msg;
            shreg   <= msg;
            bit_cnt <= '0;
            rep_cnt <= '0;
            busy    <= 1'b1;
            if (bit_req) tx_bit <= 1'b1;
        end else if (busy && bit_req) begin
            tx_bit <= shreg[MSG_LEN-1];
            if (last_bit) begin
                shreg   <= msg_q;
                bit_cnt <= '0;
                if (last_rep) begin
                    busy    <= 1'b0;
                    rep_cnt <= '0;
                end else begin
                    rep_cnt <= rep_cnt + 1'b1;
                end
            end else begin
                shreg   <= {shreg[MSG_LEN-2:0], 1'b1};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end else if (bit_req) begin
            tx_bit <= 1'b1;
        end
    end
endmodule

// File: rtl/feac_tx.sv
// Module: top of the alarm/control code transmitter. Joins the register
// file, message framer and serializer. Assumes bit_req comes from the
// framer's overhead timing, already synchronous to clk.
module feac_tx
    import feac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bit_req,
    output logic              tx_bit,
    output logic              irq
);
    logic [CODE_W-1:0]  code_w;
    logic [MSG_LEN-1:0] msg_w;
    logic               en_w;
    logic               ien_w;
    logic               go_w;
    logic               stat_w;
    logic               busy_w;
    logic               done_w;

    feac_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .rd    (reg_rd),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .busy  (busy_w),
        .done  (done_w),
        .rdata (reg_rdata),
        .code  (code_w),
        .en    (en_w),
        .ien   (ien_w),
        .go    (go_w),
        .stat  (stat_w)
    );

    feac_msg_build u_build (
        .code (code_w),
        .msg  (msg_w)
    );

    feac_serializer u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_w),
        .start   (go_w),
        .msg     (msg_w),
        .bit_req (bit_req),
        .tx_bit  (tx_bit),
        .busy    (busy_w),
        .done    (done_w)
    );

    // Interrupt output: status gated by its enable.
    assign irq = stat_w && ien_w;
endmodule

// File: rtl/feac_tx_chk.sv
// Module: assertion checker bound to feac_tx. Observes ports and the
// signals passed between the register file and the serializer.
module feac_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_req,
    input logic       tx_bit,
    input logic       irq,
    input logic       reg_rd,
    input logic [7:0] reg_addr,
    input logic       busy,
    input logic       en,
    input logic       ien,
    input logic       stat,
    input logic       done
);
    // R3: line output only moves on a strobe.
    a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_req |=> $stable(tx_bit));

    // R4: idle strobes send ones.
    a_r4_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bit_req) |=> tx_bit);

    // R5: completion ends busy.
    a_r5_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8: completion always sets the status, even against a read.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> stat);

    // R8: a read without completion clears the status.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 8'h31 && !done) |=> !stat);

    // R9: interrupt never fires while masked.
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);

    // R10: disabling the block aborts a run.
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en) |=> !busy);
endmodule

bind feac_tx feac_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_req  (bit_req),
    .tx_bit   (tx_bit),
    .irq      (irq),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .busy     (busy_w),
    .en       (en_w),
    .ien      (ien_w),
    .stat     (stat_w),
    .done     (done_w)
);

// File: tb/test_feac_tx.sv
`timescale 1ns/1ps
module test_feac_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       bit_req = 1'b0;
    logic       tx_bit;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [7:0] CSR  = 8'h31;
    localparam logic [7:0] CODE = 8'h32;

    feac_tx i_feac_tx (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_req(bit_req), .tx_bit(tx_bit), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Expected line bit for message position idx (R3 framing).
    function automatic logic exp_bit(logic [5:0] c, int idx);
        int p = idx % 16;
        if (p == 0 || p == 7) return 1'b0;
        if (p >= 1 && p <= 6) return c[6 - p];
        return 1'b1;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        bit_req = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
    endtask

    // Load code, issue go, check busy set and go cleared (R5, R6).
    task automatic start_msg(logic [5:0] c, logic [7:0] ctrl);
        logic [7:0] d;
        wr_reg(CODE, {2'b00, c});
        wr_reg(CSR, ctrl);
        @(negedge clk);
        rd_reg(CSR, d);
        chk("R5/R6 busy set, go self-cleared", d & 8'h03, 8'h01);
    endtask

    // Strobe positions [from,to) with random gaps, check each bit (R3, R4).
    task automatic send_bits(logic [5:0] c, int from, int to);
        for (int i = from; i < to; i++) begin
            int gap = $urandom_range(0, 3);
            strobe();
            chk("R3/R4 line bit", {7'd0, tx_bit}, {7'd0, exp_bit(c, i)});
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk("R3 hold between strobes", {7'd0, tx_bit}, {7'd0, exp_bit(c, i)});
            end
        end
    endtask

    // Full run with interrupt enabled, then status/irq handling (R8, R9).
    task automatic full_run(logic [5:0] c);
        logic [7:0] d;
        start_msg(c, 8'h16);
        send_bits(c, 0, 160);
        chk("R9 irq after completion", {7'd0, irq}, 8'd1);
        rd_reg(CSR, d);
        chk("R5/R8 busy clear, status set", d, 8'h1C);
        chk("R8/R9 irq cleared by read", {7'd0, irq}, 8'd0);
        rd_reg(CSR, d);
        chk("R8 status cleared", d, 8'h14);
        strobe();
        chk("R4 idle ones", {7'd0, tx_bit}, 8'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 tx idle", {7'd0, tx_bit}, 8'd1);
        chk("R1 irq low", {7'd0, irq}, 8'd0);
        rd_reg(CSR, d);  chk("R1 csr reset", d, 8'h00);
        rd_reg(CODE, d); chk("R1 code reset", d, 8'h00);

        // R2 register fields
        wr_reg(CODE, 8'hFF);
        rd_reg(CODE, d); chk("R2 code width", d, 8'h3F);
        wr_reg(CSR, 8'hF4);
        rd_reg(CSR, d);  chk("R2 csr rw bits", d, 8'h14);
        wr_reg(CSR, 8'h00);
        rd_reg(CSR, d);  chk("R2 csr cleared", d, 8'h00);

        // R6 go without enable ignored
        wr_reg(CSR, 8'h02);
        repeat (2) @(negedge clk);
        rd_reg(CSR, d);  chk("R6 go needs enable", d, 8'h00);
        strobe();
        chk("R6 line idle", {7'd0, tx_bit}, 8'd1);

        // Main function: corner and random codes
        full_run(6'h00);
        full_run(6'h3F);
        full_run(6'h15);
        full_run(6'h2A);
        for (int k = 0; k < 4; k++) full_run(6'($urandom));

        // R7/R11: go and code change mid-run
        start_msg(6'h29, 8'h16);
        send_bits(6'h29, 0, 20);
        wr_reg(CODE, 8'h16);
        wr_reg(CSR, 8'h16);
        send_bits(6'h29, 20, 160);
        rd_reg(CSR, d);  chk("R7 single run ended", d, 8'h1C);
        for (int k = 0; k < 20; k++) begin
            strobe();
            chk("R7 no second run", {7'd0, tx_bit}, 8'd1);
        end
        rd_reg(CSR, d);  chk("R7 still idle", d, 8'h14);

        // R8: read in the completion cycle
        start_msg(6'h0B, 8'h16);
        send_bits(6'h0B, 0, 159);
        @(negedge clk);
        bit_req = 1'b1; reg_rd = 1'b1; reg_addr = CSR;
        #1 chk("R8 read before set", reg_rdata, 8'h15);
        @(negedge clk);
        bit_req = 1'b0; reg_rd = 1'b0;
        chk("R8 last bit", {7'd0, tx_bit}, 8'd1);
        rd_reg(CSR, d);  chk("R8 set wins over read", d, 8'h1C);
        rd_reg(CSR, d);  chk("R8 cleared after", d, 8'h14);

        // R9: interrupt masked
        start_msg(6'h33, 8'h06);
        send_bits(6'h33, 0, 160);
        chk("R9 irq masked", {7'd0, irq}, 8'd0);
        rd_reg(CSR, d);  chk("R9 status without irq", d, 8'h0C);

        // R10: abort by disabling
        start_msg(6'h12, 8'h16);
        send_bits(6'h12, 0, 30);
        wr_reg(CSR, 8'h00);
        rd_reg(CSR, d);  chk("R10 aborted", d, 8'h00);
        for (int k = 0; k < 20; k++) begin
            strobe();
            chk("R10 ones after abort", {7'd0, tx_bit}, 8'd1);
        end
        chk("R10 no irq", {7'd0, irq}, 8'd0);
        wr_reg(CSR, 8'h14);
        rd_reg(CSR, d);  chk("R10 no status", d, 8'h14);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule